// File: doc/BRIEF.md
# LFSR-Sequenced Sequential-Access Memory

This block stores 1023 words of 10 bits. It has one write port and one read port, and neither port takes an address. Each port has its own address sequencer. Every enabled access uses the port's current location and then moves the port to the next location of a fixed sequence. A full pass touches every word exactly once. The access after the final location wraps back to the first one.

Each sequencer is a 10-bit maximal-length linear-feedback shift register rather than a binary counter. Its 1023 nonzero states match the 1023 words of the array exactly, so no adder and no range compare are needed. The read and write positions move independently, so the array works as a plain FIFO. Each port has a rewind input that returns it to the start of the sequence. Each port also has a flag that marks an access to the final location of a pass.

Top module: `seqmem_lfsr_top`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0, both last-location flags are 0, and both ports stand at the first location of the sequence.
- R2: A write stores `wr_data` at the current write location and then advances the write port by one step. An advance happens only on a clock edge where `wr_en` is high. A cycle with `wr_en` low leaves the write position unchanged.
- R3: A read presents, on `rd_data` one clock after `rd_en`, the word at the current read location, and then advances the read port by one step. While `rd_en` is low, `rd_data` holds its value and the read position is unchanged.
- R4: The sequence of locations comes from the feedback polynomial x^10 + x^7 + 1 with seed value 0x001. It visits all 1023 nonzero states before any repeats and never reaches the all-zero state. Consecutive enabled accesses therefore return the data in the order it was written.
- R5: `wr_last` (or `rd_last`) is high for exactly the one cycle after an enabled access to the 1023rd location of the sequence, and low at every other time.
- R6: The enabled access that follows the 1023rd location goes back to the first location, so a second pass overwrites, or re-reads, the words of the first pass in the same order.
- R7: A port's rewind input takes priority over its enable. A rewind alone moves the port to the first location. A rewind together with an enable performs that access at the first location and leaves the port at the second location.
- R8: When the read and the write use the same location in the same cycle, the read returns the value stored before that write.
- R9: The two ports are independent. Reads never move the write position, and writes never move the read position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write the current word and step the write position |
| wr_data | input | 10 | Data to store |
| wr_rewind | input | 1 | Return the write port to the first location |
| wr_last | output | 1 | One-cycle pulse after a write to the final location |
| rd_en | input | 1 | Read the current word and step the read position |
| rd_rewind | input | 1 | Return the read port to the first location |
| rd_data | output | 10 | Registered read data |
| rd_last | output | 1 | One-cycle pulse after a read of the final location |

## Verification
All results of this block fall due exactly one rising edge after the cycle that caused them. This covers the read word, the held read word, and both last-location pulses. The driver applies stimulus on the falling edge. At that same moment it pushes into a queue the values that the coming rising edge must produce, computing them from a model indexed by position in the pass rather than by physical address. The monitor pops one entry two nanoseconds after each rising edge and compares it, so every check lands on the cycle in which the registered output has just settled.

// File: rtl/seqmem_pkg.sv
// Package: shared defaults and port indices for the sequential-access memory.
// Assumes: the tap mask always contains the top bit of the register.
package seqmem_pkg;

    // Default geometry: 10-bit sequencer and 10-bit words.
    localparam int DEF_ADDR_W = 10;
    localparam int DEF_DATA_W = 10;

    // Taps for x^10 + x^7 + 1: state bits 9 and 6 feed the new bit.
    localparam logic [DEF_ADDR_W-1:0] DEF_TAP_MASK = 10'h240;

    // First location of every pass.
    localparam logic [DEF_ADDR_W-1:0] DEF_SEED = 10'h001;

    // Index of each port in the sequencer array.
    typedef enum int {
        PORT_WR = 0,
        PORT_RD = 1
    } seq_port_e;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/seqmem_lfsr_seq.sv
// Module: per-port address sequencer built from a Fibonacci LFSR.
// Produces the address used in the current cycle and a registered pulse
// that follows an access to the final state of the cycle.
// Assumes: TAP_MASK describes a maximal-length polynomial whose top bit
// is set, and SEED is nonzero.
module seqmem_lfsr_seq #(
    parameter int                ADDR_W   = seqmem_pkg::DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] TAP_MASK = seqmem_pkg::DEF_TAP_MASK,
    parameter logic [ADDR_W-1:0] SEED     = seqmem_pkg::DEF_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rewind_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    // One forward step: shift left and insert the parity of the tapped bits.
    function automatic logic [ADDR_W-1:0] lfsr_next(input logic [ADDR_W-1:0] s);
        return {s[ADDR_W-2:0], ^(s & TAP_MASK)};
    endfunction

    // One backward step: recover the bit that was shifted out at the top.
    function automatic logic [ADDR_W-1:0] lfsr_prev(input logic [ADDR_W-1:0] s);
        logic [ADDR_W-1:0] p;
        p = {1'b0, s[ADDR_W-1:1]};
        p[ADDR_W-1] = s[0] ^ (^(p & TAP_MASK));
        return p;
    endfunction

    // The state just before the seed is the final location of a pass.
    localparam logic [ADDR_W-1:0] LAST_STATE = lfsr_prev(SEED);
    // The state a rewinding access leaves behind.
    localparam logic [ADDR_W-1:0] SEED_NEXT  = lfsr_next(SEED);

    logic [ADDR_W-1:0] state_q;
    logic              last_q;

    // Address for this cycle: rewind overrides the stored position.
    always_comb begin
        addr_o = rewind_i ? SEED : state_q;
    end

    // Position register: rewind first, then an enabled step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (rewind_i) begin
            state_q <= en_i ? SEED_NEXT : SEED;
        end else if (en_i) begin
            state_q <= lfsr_next(state_q);
        end
    end

    // Final-location pulse: set after an enabled access to LAST_STATE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= en_i && (addr_o == LAST_STATE);
        end
    end

    assign last_o = last_q;

    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);  // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !rewind_i) |=> $stable(state_q));  // R2

    AST_REWIND_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_i && !en_i) |=> (state_q == SEED));  // R7

    AST_WRAP_TO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !rewind_i && state_q == LAST_STATE) |=> (state_q == SEED));  // R6

    AST_LAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o);  // R5

endmodule

// File: rtl/seqmem_array.sv
// Module: storage array with one write port and one registered read port.
// Locations are numbered 1..DEPTH, which matches the nonzero LFSR states.
// A read and a write to one location in one cycle return the old word.
// Assumes: addresses are never zero and never exceed DEPTH.
module seqmem_array #(
    parameter int DATA_W = seqmem_pkg::DEF_DATA_W,
    parameter int ADDR_W = seqmem_pkg::DEF_ADDR_W,
    parameter int DEPTH  = (1 << ADDR_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [1:DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Write process: store the word at the write address; no reset on the array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read process: capture the stored word; nonblocking update gives read-before-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));  // R3

    AST_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en |-> wr_addr != '0) and (rd_en |-> rd_addr != '0));  // R4

endmodule

// File: rtl/seqmem_lfsr_top.sv
// Module: sequential-access memory with independent LFSR-driven ports.
// Two sequencer instances, one per port, feed the storage array.
// Assumes: 2**ADDR_W - 1 words, so every LFSR state names one word.
module seqmem_lfsr_top #(
    parameter int                DATA_W   = seqmem_pkg::DEF_DATA_W,
    parameter int                ADDR_W   = seqmem_pkg::DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] TAP_MASK = seqmem_pkg::DEF_TAP_MASK,
    parameter logic [ADDR_W-1:0] SEED     = seqmem_pkg::DEF_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_rewind,
    output logic              wr_last,
    input  logic              rd_en,
    input  logic              rd_rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);

    import seqmem_pkg::*;

    localparam int DEPTH = (1 << ADDR_W) - 1;
    localparam int WR_I  = int'(PORT_WR);
    localparam int RD_I  = int'(PORT_RD);

    logic [NUM_PORTS-1:0] port_en;
    logic [NUM_PORTS-1:0] port_rewind;
    logic [NUM_PORTS-1:0] port_last;
    logic [ADDR_W-1:0]    port_addr [NUM_PORTS];

    // Gather per-port controls into indexed vectors.
    always_comb begin
        port_en[WR_I]     = wr_en;
        port_en[RD_I]     = rd_en;
        port_rewind[WR_I] = wr_rewind;
        port_rewind[RD_I] = rd_rewind;
    end

    // One sequencer per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_seq
        seqmem_lfsr_seq #(
            .ADDR_W   (ADDR_W),
            .TAP_MASK (TAP_MASK),
            .SEED     (SEED)
        ) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (port_en[p]),
            .rewind_i (port_rewind[p]),
            .addr_o   (port_addr[p]),
            .last_o   (port_last[p])
        );
    end

    seqmem_array #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (port_addr[WR_I]),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (port_addr[RD_I]),
        .rd_data (rd_data)
    );

    assign wr_last = port_last[WR_I];
    assign rd_last = port_last[RD_I];

    AST_REWIND_ADDR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rewind |-> port_addr[WR_I] == SEED) and
        (rd_rewind |-> port_addr[RD_I] == SEED));  // R7

    AST_RD_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rd_rewind) |=> $stable(port_addr[RD_I]) || rd_rewind);  // R9

endmodule

// File: tb/seqmem_lfsr_top_tb_top.sv
// Bench: scoreboard for the sequential-access memory. The driver applies
// one cycle of stimulus on the falling edge and queues what the next
// rising edge must produce. The monitor pops and compares just after
// that edge. The model is indexed by position within a pass (0..1022).
module seqmem_lfsr_top_tb_top;

    localparam int    DW    = 10;
    localparam int    NPOS  = 1023;
    localparam time   TCLK  = 8ns;

    typedef struct {
        logic [DW-1:0] rd_exp;
        bit            rd_known;
        bit            rd_last_exp;
        bit            wr_last_exp;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_rewind = 1'b0;
    logic          wr_last;
    logic          rd_en = 1'b0;
    logic          rd_rewind = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_last;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    exp_t          q[$];
    logic [DW-1:0] m_mem [NPOS];
    bit            m_valid [NPOS];
    int            wpos = 0;
    int            rpos = 0;
    logic [DW-1:0] cur_rd = '0;
    bit            cur_known = 1'b1;

    always #(TCLK/2) clk = ~clk;

    seqmem_lfsr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_rewind (wr_rewind),
        .wr_last   (wr_last),
        .rd_en     (rd_en),
        .rd_rewind (rd_rewind),
        .rd_data   (rd_data),
        .rd_last   (rd_last)
    );

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Driver: one cycle of stimulus plus the expected results of that edge.
    task automatic drive(bit we, bit wrw, bit re, bit rrw, logic [DW-1:0] wd, string tag);
        exp_t it;
        int   weff;
        int   reff;
        @(negedge clk);
        wr_en = we; wr_rewind = wrw; wr_data = wd;
        rd_en = re; rd_rewind = rrw;
        weff = wrw ? 0 : wpos;
        reff = rrw ? 0 : rpos;
        if (re) begin
            cur_known = m_valid[reff];
            cur_rd    = m_mem[reff];   // old value before this cycle's write (R8)
        end
        it.rd_exp      = cur_rd;
        it.rd_known    = cur_known;
        it.rd_last_exp = re && (reff == NPOS-1);
        it.wr_last_exp = we && (weff == NPOS-1);
        it.tag         = tag;
        if (we) begin
            m_mem[weff]   = wd;
            m_valid[weff] = 1'b1;
        end
        wpos = we ? (weff + 1) % NPOS : weff;
        rpos = re ? (reff + 1) % NPOS : reff;
        q.push_back(it);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, '0, tag);
    endtask

    // Monitor: compare the queued expectation just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2ns;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check(wr_last == it.wr_last_exp, {it.tag, " wr_last"},
                      {9'd0, wr_last}, {9'd0, it.wr_last_exp});
                check(rd_last == it.rd_last_exp, {it.tag, " rd_last"},
                      {9'd0, rd_last}, {9'd0, it.rd_last_exp});
                if (it.rd_known)
                    check(rd_data === it.rd_exp, {it.tag, " rd_data"}, rd_data, it.rd_exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
        end
    end

    function automatic logic [DW-1:0] pat(int k, int base);
        return DW'((k * 37 + base) % 1024);
    endfunction

    initial begin
        for (int i = 0; i < NPOS; i++) m_valid[i] = 1'b0;

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(rd_data == '0, "R1 rd_data after reset", rd_data, '0);
        check(!wr_last && !rd_last, "R1 flags after reset",
              {8'd0, wr_last, rd_last}, '0);

        // R2 R4 R5: one full write pass with idle gaps; wr_last on the 1023rd.
        for (int k = 0; k < NPOS; k++) begin
            drive(1, 0, 0, 0, pat(k, 5), "R2/R4/R5 write pass");
            if (k % 7 == 3) drive(0, 0, 0, 0, '0, "R2 idle hold");
        end
        idle(2, "R5 wr_last low after pulse");

        // R3 R4 R5 R9: read the pass back in order with gaps (reads start at first location).
        for (int k = 0; k < NPOS; k++) begin
            drive(0, 0, 1, 0, '0, "R3/R4/R9 read pass");
            if (k % 5 == 1) drive(0, 0, 0, 0, '0, "R3 rd_data hold");
        end
        idle(2, "R5 rd_last low after pulse");

        // R6: second pass wraps to the first location on both ports.
        for (int k = 0; k < 6; k++) drive(1, 0, 0, 0, pat(k, 300), "R6 write wrap");
        for (int k = 0; k < 6; k++) drive(0, 0, 1, 0, '0, "R6 read wrap");

        // R7: rewind alone, then access first and second locations.
        drive(0, 1, 0, 1, '0, "R7 rewind alone");
        drive(1, 0, 0, 0, 10'h155, "R7 write after rewind");
        drive(1, 0, 0, 0, 10'h0AA, "R7 second write");
        drive(0, 0, 1, 0, '0, "R7 read after rewind");
        drive(0, 0, 1, 0, '0, "R7 second read");

        // R7: rewind together with enable accesses first location, leaves port on second.
        drive(1, 1, 0, 0, 10'h3C3, "R7 rewind with write");
        drive(1, 0, 0, 0, 10'h21E, "R7 write after rewind+write");
        drive(0, 0, 1, 1, '0, "R7 rewind with read");
        drive(0, 0, 1, 0, '0, "R7 read after rewind+read");

        // R8: both ports on the same location in the same cycle.
        drive(1, 1, 1, 1, 10'h111, "R8 read-before-write at first");
        drive(1, 0, 1, 0, 10'h222, "R8 read-before-write at second");
        drive(0, 1, 0, 1, '0, "R8 rewind both");
        drive(0, 0, 1, 0, '0, "R8 new value visible");
        drive(0, 0, 1, 0, '0, "R8 new value visible 2");

        // R9: reads do not move the write port; writes do not move the read port.
        drive(0, 1, 0, 1, '0, "R9 rewind both");
        for (int k = 0; k < 10; k++) drive(0, 0, 1, 0, '0, "R9 reads only");
        for (int k = 0; k < 4; k++)  drive(1, 0, 0, 0, pat(k, 700), "R9 writes only");
        drive(0, 1, 0, 0, '0, "R9 rewind write only");
        for (int k = 0; k < 4; k++)  drive(0, 0, 1, 0, '0, "R9 read continues");
        drive(0, 0, 0, 1, '0, "R9 rewind read");
        for (int k = 0; k < 4; k++)  drive(0, 0, 1, 0, '0, "R9 read start");

        // R5 R6: drive the read port through a whole pass to the final location again.
        drive(0, 0, 0, 1, '0, "R5 rewind read");
        for (int k = 0; k < NPOS + 2; k++) drive(0, 0, 1, 0, '0, "R5/R6 second read pass");

        // R1: reset mid-run returns both ports to the first location; array keeps data.
        @(negedge clk);
        wr_en = 0; rd_en = 0; wr_rewind = 0; rd_rewind = 0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        q.delete();
        check(rd_data == '0, "R1 rd_data after second reset", rd_data, '0);
        wpos = 0; rpos = 0; cur_rd = '0; cur_known = 1'b1;
        for (int k = 0; k < 3; k++) drive(0, 0, 1, 0, '0, "R1 read from first after reset");

        idle(3, "drain");
        done = 1'b1;
        summary();
    end

endmodule